// File: doc/BRIEF.md
# Glitch-Free Differential Clock Stop Gate

This block sits between an internal clock divider and a set of differential clock output pairs. It drives, for every pair, a true level, a complement level and an output-enable bit that selects between driving the pair and tri-stating it. A single fast source clock runs all of the logic. A free-running divider inside the block turns that clock into the output clock. Each output period is `2*HALF_DIV` source cycles long.

An active-low stop request can arrive at any time from another clock domain. Each pair has a stoppable flag. When stop is active, pairs with the flag set freeze at a clean level on their next high-to-low boundary. Pairs without the flag keep toggling. The shared `hiz_mode` input picks how a frozen pair rests:
- Driven mode: true high, complement low.
- Tri-state mode: the pair is released.

When stop is released, a frozen pair is first driven high. It then rejoins the clock on a high-to-low boundary, so no high or low phase is ever cut short. A separate enable flag per pair overrides all of this and tri-states the pair.

Top module: `diff_stop_ctrl`

## Requirements
- R1: After reset, every enabled pair is driven (`dif_oe`=1) with true low and complement high, and it starts toggling.
- R2: A pair whose stoppable flag is 0 keeps toggling while stop is active.
- R3: In driven mode (`hiz_mode`=0), a stoppable pair freezes at true=1, complement=0, `dif_oe`=1. The freeze happens at the first high-to-low boundary of the internal clock that follows recognition of the stop.
- R4: In tri-state mode (`hiz_mode`=1), a frozen pair shows `dif_oe`=0 with true and complement both 0.
- R5: `stop_n` passes through a two-flop synchronizer. The gates act on its value two source cycles after the line changes.
- R6: On release, a frozen pair is driven high (`dif_oe`=1, true 1, complement 0) no more than three source cycles after `stop_n` rises, in either mode.
- R7: A released pair resumes toggling on the third high-to-low boundary after it starts the pre-drive. Its first falling true edge comes between 2 and 6 output periods after `stop_n` rises.
- R8: While a pair stays driven, no high or low phase of its true output is shorter than `HALF_DIV` source cycles.
- R9: Whenever `dif_oe` is 1, the complement equals the inverse of true. Whenever `dif_oe` is 0, both are 0.
- R10: A pair whose enable flag is 0 is tri-stated with both levels 0 from the next cycle, whatever the stop input does.
- R11: A running pair toggles with a period of `2*HALF_DIV` source cycles, in phase with the internal divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_n | input | 1 | Asynchronous active-low stop request |
| hiz_mode | input | 1 | 0: frozen pairs rest driven high; 1: frozen pairs tri-state |
| out_en | input | NPAIRS | Per-pair enable flag |
| stop_able | input | NPAIRS | Per-pair stoppable flag |
| dif_p | output | NPAIRS | True level of each pair |
| dif_n | output | NPAIRS | Complement level of each pair |
| dif_oe | output | NPAIRS | Drive enable of each pair (0 = tri-state) |

## Verification
The hardest case to reach is a pair that is re-stopped while it is still in pre-drive, before it has rejoined the clock. The stimulus releases stop for only three source cycles and then asserts it again, so the pre-drive state returns to the frozen state. One-cycle stop pulses are also applied. Because of the synchronizer, such a pulse can arm a pair without freezing it, or freeze it only briefly. A behavioural reference model checks every cycle, and a phase-length monitor catches any runt pulse these cases might produce.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [1:0] {
    GS_RUN  = 2'd0,
    GS_ARM  = 2'd1,
    GS_HELD = 2'd2,
    GS_WARM = 2'd3
  } gate_st_t;
endpackage

// File: rtl/dsc_stop_sync.sv
module dsc_stop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic stop_n,
  output logic halt_req
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-2:0], stop_n};
  end

  assign halt_req = ~sh[STAGES-1];
endmodule

// File: rtl/dsc_phase_gen.sv
module dsc_phase_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  output logic ck_nx,
  output logic fall_evt
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          ck;
  logic          wrap;

  assign wrap     = (cnt == LAST);
  assign fall_evt = wrap & ck;
  assign ck_nx    = wrap ? ~ck : ck;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ck  <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      ck  <= ~ck;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  // R11
  wrap_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    fall_evt |=> !ck);
endmodule

// File: rtl/dsc_pair_gate.sv
module dsc_pair_gate
  import dsc_pkg::*;
#(
  parameter int RESUME_FALLS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic halt,
  input  logic hiz_mode,
  input  logic en,
  input  logic fall_evt,
  input  logic ck_nx,
  output logic p,
  output logic n,
  output logic oe
);
  localparam int WW = $clog2(RESUME_FALLS + 1);
  localparam logic [WW-1:0] WLAST = WW'(RESUME_FALLS - 1);

  gate_st_t       st, st_nx;
  logic [WW-1:0]  warm, warm_nx;
  logic           p_nx, oe_nx;

  always_comb begin
    st_nx   = st;
    warm_nx = warm;
    unique case (st)
      GS_RUN:  if (halt) st_nx = GS_ARM;
      GS_ARM:  begin
        if (!halt)         st_nx = GS_RUN;
        else if (fall_evt) st_nx = GS_HELD;
      end
      GS_HELD: if (!halt) begin
        st_nx   = GS_WARM;
        warm_nx = '0;
      end
      GS_WARM: begin
        if (halt) st_nx = GS_HELD;
        else if (fall_evt) begin
          if (warm == WLAST) st_nx = GS_RUN;
          else               warm_nx = warm + WW'(1);
        end
      end
    endcase
    if (!en) begin
      st_nx   = GS_RUN;
      warm_nx = '0;
    end
  end

  always_comb begin
    if (!en) begin
      oe_nx = 1'b0;
      p_nx  = 1'b0;
    end else begin
      unique case (st_nx)
        GS_RUN, GS_ARM: begin oe_nx = 1'b1;      p_nx = ck_nx;     end
        GS_HELD:        begin oe_nx = ~hiz_mode; p_nx = ~hiz_mode; end
        GS_WARM:        begin oe_nx = 1'b1;      p_nx = 1'b1;      end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= GS_RUN;
      warm <= '0;
      p    <= 1'b0;
      n    <= 1'b1;
      oe   <= 1'b1;
    end else begin
      st   <= st_nx;
      warm <= warm_nx;
      p    <= p_nx;
      n    <= oe_nx & ~p_nx;
      oe   <= oe_nx;
    end
  end

  // R9
  compl_pair_chk: assert property (@(posedge clk) disable iff (rst)
    oe ? (n == ~p) : (!n && !p));

  // R10
  dis_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!oe && !p && !n));

  // R3
  halt_level_chk: assert property (@(posedge clk) disable iff (rst)
    (st == GS_ARM && halt && fall_evt && en && !hiz_mode) |=> (oe && p && !n));

  // R6
  predrive_chk: assert property (@(posedge clk) disable iff (rst)
    (st == GS_HELD && !halt && en) |=> (oe && p && !n));
endmodule

// File: rtl/diff_stop_ctrl.sv
module diff_stop_ctrl #(
  parameter int NPAIRS       = 4,
  parameter int HALF_DIV     = 2,
  parameter int SYNC_STAGES  = 2,
  parameter int RESUME_FALLS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop_n,
  input  logic              hiz_mode,
  input  logic [NPAIRS-1:0] out_en,
  input  logic [NPAIRS-1:0] stop_able,
  output logic [NPAIRS-1:0] dif_p,
  output logic [NPAIRS-1:0] dif_n,
  output logic [NPAIRS-1:0] dif_oe
);
  logic halt_req;
  logic ck_nx;
  logic fall_evt;

  dsc_stop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .stop_n   (stop_n),
    .halt_req (halt_req)
  );

  dsc_phase_gen #(.HALF_DIV(HALF_DIV)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .ck_nx    (ck_nx),
    .fall_evt (fall_evt)
  );

  for (genvar g = 0; g < NPAIRS; g++) begin : g_pair
    dsc_pair_gate #(.RESUME_FALLS(RESUME_FALLS)) u_gate (
      .clk      (clk),
      .rst      (rst),
      .halt     (halt_req & stop_able[g]),
      .hiz_mode (hiz_mode),
      .en       (out_en[g]),
      .fall_evt (fall_evt),
      .ck_nx    (ck_nx),
      .p        (dif_p[g]),
      .n        (dif_n[g]),
      .oe       (dif_oe[g])
    );
  end
endmodule

// File: tb/diff_stop_ctrl_bench.sv
`timescale 1ns/1ps
module diff_stop_ctrl_bench;
  localparam int NP = 4;
  localparam int H  = 2;
  localparam int RF = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_n = 1'b1;
  logic hiz_mode = 1'b0;
  logic [NP-1:0] out_en = '1;
  logic [NP-1:0] stop_able = '0;
  logic [NP-1:0] dif_p, dif_n, dif_oe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  diff_stop_ctrl #(.NPAIRS(NP), .HALF_DIV(H), .SYNC_STAGES(2), .RESUME_FALLS(RF))
    u_diff_stop_ctrl (
      .clk(clk), .rst(rst), .stop_n(stop_n), .hiz_mode(hiz_mode),
      .out_en(out_en), .stop_able(stop_able),
      .dif_p(dif_p), .dif_n(dif_n), .dif_oe(dif_oe));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: 0 run, 1 armed, 2 frozen, 3 pre-drive
  int  mcnt;
  bit  mck, sA, sB;
  int  mode [NP];
  int  warm [NP];
  bit  ep [NP], en_ [NP], eoe [NP];
  int  cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mcnt = 0; mck = 0; sA = 1; sB = 1;
      for (int i = 0; i < NP; i++) begin
        mode[i] = 0; warm[i] = 0; ep[i] = 0; en_[i] = 1; eoe[i] = 1;
      end
    end else begin
      bit fall, ck_new, hl;
      fall   = (mcnt == H-1) && mck;
      ck_new = (mcnt == H-1) ? !mck : mck;
      for (int i = 0; i < NP; i++) begin
        hl = !sB && stop_able[i];
        if (!out_en[i]) begin mode[i] = 0; warm[i] = 0; end
        else if (mode[i] == 0) begin if (hl) mode[i] = 1; end
        else if (mode[i] == 1) begin
          if (!hl) mode[i] = 0; else if (fall) mode[i] = 2;
        end else if (mode[i] == 2) begin
          if (!hl) begin mode[i] = 3; warm[i] = 0; end
        end else begin
          if (hl) mode[i] = 2;
          else if (fall) begin
            if (warm[i] == RF-1) mode[i] = 0; else warm[i]++;
          end
        end
        if (!out_en[i])      begin eoe[i] = 0; ep[i] = 0; end
        else if (mode[i] < 2) begin eoe[i] = 1; ep[i] = ck_new; end
        else if (mode[i] == 2) begin eoe[i] = !hiz_mode; ep[i] = !hiz_mode; end
        else                  begin eoe[i] = 1; ep[i] = 1; end
        en_[i] = eoe[i] && !ep[i];
      end
      sB = sA; sA = stop_n;
      mcnt = (mcnt == H-1) ? 0 : mcnt + 1;
      mck = ck_new;
    end
  end

  // Per-cycle comparison, complement rule and phase-length monitor
  int  last_chg [NP];
  bit  trk [NP];
  bit  prev_p [NP], prev_oe [NP];

  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < NP; i++) begin
        string tag;
        if (!out_en[i])                     tag = "R10";
        else if (sB != stop_n)              tag = "R5";
        else if (mode[i] == 2)              tag = hiz_mode ? "R4" : "R3";
        else if (mode[i] == 3)              tag = "R6";
        else if (!stop_n && !stop_able[i])  tag = "R2";
        else                                tag = "R11";
        check({dif_p[i], dif_n[i], dif_oe[i]} == {ep[i], en_[i], eoe[i]}, tag,
              {dif_p[i], dif_n[i], dif_oe[i]}, {ep[i], en_[i], eoe[i]});
        // R9 complement rule
        check(dif_oe[i] ? (dif_n[i] == !dif_p[i]) : (!dif_n[i] && !dif_p[i]), "R9",
              {dif_n[i], dif_p[i]}, dif_oe[i] ? {!dif_p[i], dif_p[i]} : 0);
        // R8 phase length
        if (dif_oe[i] && prev_oe[i]) begin
          if (dif_p[i] != prev_p[i]) begin
            if (trk[i]) check(cyc - last_chg[i] >= H, "R8", cyc - last_chg[i], H);
            last_chg[i] = cyc; trk[i] = 1;
          end
        end else trk[i] = 0;
        prev_p[i] = dif_p[i]; prev_oe[i] = dif_oe[i];
      end
    end
  end

  task automatic wait_cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  // R7: first falling true edge after release must land within 2..6 periods
  task automatic release_and_time(input int idx);
    int lat = 0;
    bit seen_hi = 0;
    stop_n = 1'b1;
    while (lat < 100) begin
      @(negedge clk); lat++;
      if (dif_oe[idx] && dif_p[idx]) seen_hi = 1;
      else if (seen_hi && dif_oe[idx] && !dif_p[idx]) break;
    end
    check(lat >= 2*2*H && lat <= 6*2*H, "R7", lat, 2*2*H);
  endtask

  initial begin
    int tog;
    wait_cyc(5);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(dif_oe == '1 && dif_p == '0 && dif_n == '1, "R1", {dif_oe, dif_p, dif_n}, {4'hF, 4'h0, 4'hF});
    wait_cyc(20);

    // Driven mode, pairs 0 and 1 stoppable
    stop_able = 4'b0011;
    stop_n = 1'b0;
    tog = 0;
    for (int k = 0; k < 40; k++) begin
      logic pv;
      pv = dif_p[2];
      @(negedge clk);
      if (dif_p[2] != pv) tog++;
    end
    check(tog >= 10, "R2", tog, 10);
    check(dif_p[0] && !dif_n[0] && dif_oe[0], "R3", {dif_p[0], dif_n[0], dif_oe[0]}, 3'b101);
    release_and_time(0);
    wait_cyc(30);

    // Tri-state mode, pairs 0 and 2 stoppable
    hiz_mode = 1'b1;
    stop_able = 4'b0101;
    stop_n = 1'b0;
    wait_cyc(30);
    check(!dif_oe[0] && !dif_p[0] && !dif_n[0], "R4", {dif_oe[0], dif_p[0], dif_n[0]}, 0);
    stop_n = 1'b1;
    wait_cyc(3);
    check(dif_oe[0] && dif_p[0] && !dif_n[0], "R6", {dif_oe[0], dif_p[0], dif_n[0]}, 3'b110);
    wait_cyc(40);

    // Disabled pair during stop
    out_en = 4'b1011;
    stop_n = 1'b0;
    wait_cyc(2);
    check(!dif_oe[2] && !dif_p[2] && !dif_n[2], "R10", {dif_oe[2], dif_p[2], dif_n[2]}, 0);
    wait_cyc(28);
    stop_n = 1'b1;
    wait_cyc(30);
    out_en = '1;
    wait_cyc(20);

    // Re-stop during pre-drive, driven mode
    hiz_mode = 1'b0;
    stop_able = 4'b1111;
    stop_n = 1'b0;
    wait_cyc(30);
    stop_n = 1'b1;
    wait_cyc(3);
    stop_n = 1'b0;
    wait_cyc(20);
    release_and_time(3);
    wait_cyc(20);

    // Single-cycle stop pulses at varied phases
    for (int k = 0; k < 6; k++) begin
      stop_n = 1'b0;
      wait_cyc(1);
      stop_n = 1'b1;
      wait_cyc(7 + k);
    end
    hiz_mode = 1'b1;
    for (int k = 0; k < 4; k++) begin
      stop_n = 1'b0;
      wait_cyc(1 + k);
      stop_n = 1'b1;
      wait_cyc(20);
    end
    wait_cyc(30);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule